// File: doc/BRIEF.md
# Data Access Translation and Fault Classifier

This block sits between a load/store unit and the memory system. Each cycle it may accept one data access: a virtual address, an access size in bytes, a store flag, a request for untranslated (physical) access, flags that choose the alternate privilege mode and mark a page-table fetch, the current and alternate privilege modes, and an indicator that the core is in privileged-firmware mode. In the same cycle it accepts the answer of an external translation buffer for that address: a hit flag, a physical page number, per-mode read and write enable masks and two fault-on bits.

One cycle later it returns either a physical address, with an uncacheable flag, or exactly one fault code with a status vector for the fault handler. The checks run in a fixed order: alignment, physical bypass, address validity, the kernel-only direct-mapped window, translation miss, permissions, physical range and the I/O space rules. The first check that fails decides the fault.

Top module: `dtx_translate`

## Requirements
- R1: A request whose address has any bit set in (address AND (size - 1)) gives fault code 1 (misaligned) before any other check; status bit 0 (store) equals the store flag and no other status bit is set.
- R2: The effective mode used for the permission masks is the alternate mode when the firmware indicator and the alternate flag are both set, kernel (0) when only the firmware indicator is set, and the current mode otherwise. Modes are kernel 0, executive 1, supervisor 2, user 3, and mask bit i belongs to mode i.
- R3: With the physical flag set (and the access aligned), the candidate physical address is the virtual address unchanged; validity, window, miss and permission checks are skipped.
- R4: If virtual address bits 63:42 are neither all zero nor all one, the result is fault code 2 (page fault) with status bits 5 (bad address) and 1 (access violation) set, and bit 0 set for stores.
- R5: An access whose virtual bits 47:41 equal 0x7e uses the direct-mapped window; when the current mode (not the effective mode) is not kernel it gives fault code 3 (access violation) with status bit 1 set and bit 0 set for stores.
- R6: In kernel mode the window address is virtual bits 43:0 with bits 43:41 replaced by copies of bit 40.
- R7: A translation miss gives fault code 4 when the page-table flag is set and 5 otherwise, with status bit 4 (miss) set and bit 0 set for stores.
- R8: On a hit the candidate physical address is the page number shifted left by 13 plus virtual bits 12:0.
- R9: A store with the write-enable bit for the effective mode clear gives fault code 2 with status bits 0 and 1, plus bit 3 if the fault-on-write bit is set; with the enable set but fault-on-write set it gives fault code 2 with status bits 0 and 3.
- R10: A load with the read-enable bit clear gives fault code 3 with status bit 1, plus bit 2 if fault-on-read is set; with the enable set but fault-on-read set it gives fault code 2 with status bit 2 only.
- R11: A candidate physical address with any bit above bit 43 set gives fault code 6 (machine check) with an all-zero status.
- R12: With bit 43 set, an address whose bits 43:20 are all ones gives fault code 7 (unimplemented) with zero status; any other such address is returned with the uncacheable flag set and bits 42:35 cleared.
- R13: The response appears exactly one cycle after the request with the valid flag set; a cycle without a request, and the state after reset, give valid 0 with every other output zero; a fault returns a zero address and a clear uncacheable flag; a successful translation returns code 0 and zero status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_va | input | VA_W | Virtual address |
| req_size | input | SZ_W | Access size in bytes (1, 2, 4 or 8) |
| req_write | input | 1 | Store when set, load when clear |
| req_phys | input | 1 | Untranslated access |
| req_alt | input | 1 | Use the alternate mode in firmware mode |
| req_vpte | input | 1 | Access is a page-table fetch |
| req_cur_mode | input | 2 | Current privilege mode |
| req_alt_mode | input | 2 | Alternate privilege mode |
| req_pal | input | 1 | Core runs privileged firmware |
| tlb_hit | input | 1 | Translation buffer hit |
| tlb_ppn | input | PPN_W | Physical page number |
| tlb_rd_en | input | NMODE | Read enable per mode |
| tlb_wr_en | input | NMODE | Write enable per mode |
| tlb_fault_rd | input | 1 | Fault-on-read bit |
| tlb_fault_wr | input | 1 | Fault-on-write bit |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | PA_W | Physical address (zero on a fault) |
| rsp_fault | output | 3 | Fault code, 0 when none |
| rsp_stat | output | 6 | Memory-management status bits |
| rsp_uncached | output | 1 | Address lies in uncacheable space |

## Verification
The bench builds the block with its default parameters: a 64-bit virtual address that is valid only when sign-extended from bit 42, a 44-bit physical space, 8 KB pages and a 32-bit page number. The page number is wide enough that a hit can yield a 45-bit address, which makes the machine-check path reachable through a hit as well as through physical bypass. The direct-mapped window with bit 40 set lands in the I/O half, so one address exercises R6 and R12 together.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_ALIGN     = 3'd1,
    FLT_PAGE      = 3'd2,
    FLT_ACV       = 3'd3,
    FLT_PTE_MISS  = 3'd4,
    FLT_NORM_MISS = 3'd5,
    FLT_MCHK      = 3'd6,
    FLT_UNIMP     = 3'd7
  } fault_e;

  typedef enum logic [1:0] {
    MODE_KERN  = 2'd0,
    MODE_EXEC  = 2'd1,
    MODE_SUPER = 2'd2,
    MODE_USER  = 2'd3
  } mode_e;

  localparam int ST_W     = 6;
  localparam int ST_WR    = 0;
  localparam int ST_ACV   = 1;
  localparam int ST_FONR  = 2;
  localparam int ST_FONW  = 3;
  localparam int ST_MISS  = 4;
  localparam int ST_BADVA = 5;

endpackage

// File: rtl/dtx_mode_sel.sv
module dtx_mode_sel
  import dtx_pkg::*;
#(
  parameter int MW = 2
) (
  input  logic          pal,
  input  logic          alt,
  input  logic [MW-1:0] cur_mode,
  input  logic [MW-1:0] alt_mode,
  output logic [MW-1:0] eff_mode
);

  always_comb begin
    if (pal) begin
      eff_mode = alt ? alt_mode : MW'(MODE_KERN);
    end else begin
      eff_mode = cur_mode;
    end
  end

endmodule

// File: rtl/dtx_va_check.sv
module dtx_va_check #(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 43,
  parameter int SZ_W    = 4,
  parameter int PA_W    = 44,
  parameter int SP_HI   = 47,
  parameter int SP_LO   = 41,
  parameter int SP_TAG  = 'h7e,
  parameter int EXT_BIT = 40
) (
  input  logic [VA_W-1:0] va,
  input  logic [SZ_W-1:0] size,
  output logic            misaligned,
  output logic            va_ok,
  output logic            superpage,
  output logic [PA_W-1:0] sp_pa
);

  localparam int UPPER_W = VA_W - VA_IMPL + 1;
  localparam int TAG_W   = SP_HI - SP_LO + 1;
  localparam int EXT_W   = PA_W - EXT_BIT;

  logic [UPPER_W-1:0] upper;
  logic [PA_W-1:0]    impl;
  logic [TAG_W-1:0]   tag_bits;

  assign upper    = va[VA_W-1:VA_IMPL-1];
  assign impl     = va[PA_W-1:0];
  assign tag_bits = va[SP_HI:SP_LO];

  assign misaligned = |(va[SZ_W-1:0] & (size - 1'b1));
  assign va_ok      = (&upper) | ~(|upper);
  assign superpage  = (tag_bits == SP_TAG[TAG_W-1:0]);

  // bits from EXT_BIT upward all copy bit EXT_BIT
  assign sp_pa = {{EXT_W{impl[EXT_BIT]}}, impl[EXT_BIT-1:0]};

endmodule

// File: rtl/dtx_perm_check.sv
module dtx_perm_check
  import dtx_pkg::*;
#(
  parameter int NMODE = 4,
  parameter int MW    = 2
) (
  input  logic             write,
  input  logic [MW-1:0]    eff_mode,
  input  logic [NMODE-1:0] rd_en,
  input  logic [NMODE-1:0] wr_en,
  input  logic             fault_rd,
  input  logic             fault_wr,
  output fault_e           code,
  output logic [ST_W-1:0]  stat
);

  logic allowed;

  assign allowed = write ? wr_en[eff_mode] : rd_en[eff_mode];

  always_comb begin
    code = FLT_NONE;
    stat = '0;
    if (write) begin
      if (!allowed) begin
        code          = FLT_PAGE;
        stat[ST_WR]   = 1'b1;
        stat[ST_ACV]  = 1'b1;
        stat[ST_FONW] = fault_wr;
      end else if (fault_wr) begin
        code          = FLT_PAGE;
        stat[ST_WR]   = 1'b1;
        stat[ST_FONW] = 1'b1;
      end
    end else begin
      if (!allowed) begin
        code          = FLT_ACV;
        stat[ST_ACV]  = 1'b1;
        stat[ST_FONR] = fault_rd;
      end else if (fault_rd) begin
        code          = FLT_PAGE;
        stat[ST_FONR] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dtx_pa_finish.sv
module dtx_pa_finish
  import dtx_pkg::*;
#(
  parameter int RAW_W   = 64,
  parameter int PA_W    = 44,
  parameter int CLR_HI  = 42,
  parameter int CLR_LO  = 35,
  parameter int REG_LSB = 20
) (
  input  logic [RAW_W-1:0] raw,
  output fault_e           code,
  output logic [PA_W-1:0]  pa,
  output logic             uncached
);

  localparam int UC_BIT = PA_W - 1;

  logic out_of_range;

  generate
    if (RAW_W > PA_W) begin : g_range
      assign out_of_range = |raw[RAW_W-1:PA_W];
    end else begin : g_norange
      assign out_of_range = 1'b0;
    end
  endgenerate

  always_comb begin
    code     = FLT_NONE;
    pa       = raw[PA_W-1:0];
    uncached = 1'b0;
    if (out_of_range) begin
      code = FLT_MCHK;
      pa   = '0;
    end else if (raw[UC_BIT]) begin
      if (&raw[UC_BIT:REG_LSB]) begin
        code = FLT_UNIMP;
        pa   = '0;
      end else begin
        uncached           = 1'b1;
        pa[CLR_HI:CLR_LO]  = '0;
      end
    end
  end

endmodule

// File: rtl/dtx_translate.sv
module dtx_translate
  import dtx_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int VA_IMPL  = 43,
  parameter int PA_W     = 44,
  parameter int PPN_W    = 32,
  parameter int PG_SHIFT = 13,
  parameter int SZ_W     = 4,
  parameter int NMODE    = 4,
  parameter int SP_HI    = 47,
  parameter int SP_LO    = 41,
  parameter int SP_TAG   = 'h7e,
  parameter int EXT_BIT  = 40,
  parameter int CLR_HI   = 42,
  parameter int CLR_LO   = 35,
  parameter int REG_LSB  = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic [SZ_W-1:0]  req_size,
  input  logic             req_write,
  input  logic             req_phys,
  input  logic             req_alt,
  input  logic             req_vpte,
  input  logic [1:0]       req_cur_mode,
  input  logic [1:0]       req_alt_mode,
  input  logic             req_pal,
  input  logic             tlb_hit,
  input  logic [PPN_W-1:0] tlb_ppn,
  input  logic [NMODE-1:0] tlb_rd_en,
  input  logic [NMODE-1:0] tlb_wr_en,
  input  logic             tlb_fault_rd,
  input  logic             tlb_fault_wr,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_pa,
  output logic [2:0]       rsp_fault,
  output logic [ST_W-1:0]  rsp_stat,
  output logic             rsp_uncached
);

  localparam int MW = 2;

  logic [MW-1:0]   eff_mode;
  logic            misaligned, va_ok, superpage;
  logic [PA_W-1:0] sp_pa;
  fault_e          perm_code;
  logic [ST_W-1:0] perm_stat;
  logic [VA_W-1:0] hit_raw, raw_sel;
  fault_e          fin_code;
  logic [PA_W-1:0] fin_pa;
  logic            fin_unc;

  fault_e          nxt_code;
  logic [ST_W-1:0] nxt_stat;
  logic [PA_W-1:0] nxt_pa;
  logic            nxt_unc, use_fin;

  fault_e          code_q;
  logic [ST_W-1:0] stat_q;
  logic [PA_W-1:0] pa_q;
  logic            unc_q, valid_q;

  dtx_mode_sel #(.MW(MW)) u_mode (
    .pal      (req_pal),
    .alt      (req_alt),
    .cur_mode (req_cur_mode),
    .alt_mode (req_alt_mode),
    .eff_mode (eff_mode)
  );

  dtx_va_check #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .SZ_W(SZ_W), .PA_W(PA_W),
    .SP_HI(SP_HI), .SP_LO(SP_LO), .SP_TAG(SP_TAG), .EXT_BIT(EXT_BIT)
  ) u_va (
    .va         (req_va),
    .size       (req_size),
    .misaligned (misaligned),
    .va_ok      (va_ok),
    .superpage  (superpage),
    .sp_pa      (sp_pa)
  );

  dtx_perm_check #(.NMODE(NMODE), .MW(MW)) u_perm (
    .write    (req_write),
    .eff_mode (eff_mode),
    .rd_en    (tlb_rd_en),
    .wr_en    (tlb_wr_en),
    .fault_rd (tlb_fault_rd),
    .fault_wr (tlb_fault_wr),
    .code     (perm_code),
    .stat     (perm_stat)
  );

  // page number joined with the in-page offset
  assign hit_raw = (VA_W'(tlb_ppn) << PG_SHIFT) | VA_W'(req_va[PG_SHIFT-1:0]);

  always_comb begin
    if (req_phys) begin
      raw_sel = req_va;
    end else if (superpage) begin
      raw_sel = VA_W'(sp_pa);
    end else begin
      raw_sel = hit_raw;
    end
  end

  dtx_pa_finish #(
    .RAW_W(VA_W), .PA_W(PA_W), .CLR_HI(CLR_HI), .CLR_LO(CLR_LO), .REG_LSB(REG_LSB)
  ) u_fin (
    .raw      (raw_sel),
    .code     (fin_code),
    .pa       (fin_pa),
    .uncached (fin_unc)
  );

  // fixed-priority classification
  always_comb begin
    nxt_code = FLT_NONE;
    nxt_stat = '0;
    use_fin  = 1'b0;
    if (misaligned) begin
      nxt_code        = FLT_ALIGN;
      nxt_stat[ST_WR] = req_write;
    end else if (req_phys) begin
      use_fin = 1'b1;
    end else if (!va_ok) begin
      nxt_code           = FLT_PAGE;
      nxt_stat[ST_WR]    = req_write;
      nxt_stat[ST_ACV]   = 1'b1;
      nxt_stat[ST_BADVA] = 1'b1;
    end else if (superpage) begin
      if (req_cur_mode != MW'(MODE_KERN)) begin
        nxt_code         = FLT_ACV;
        nxt_stat[ST_WR]  = req_write;
        nxt_stat[ST_ACV] = 1'b1;
      end else begin
        use_fin = 1'b1;
      end
    end else if (!tlb_hit) begin
      nxt_code          = req_vpte ? FLT_PTE_MISS : FLT_NORM_MISS;
      nxt_stat[ST_WR]   = req_write;
      nxt_stat[ST_MISS] = 1'b1;
    end else if (perm_code != FLT_NONE) begin
      nxt_code = perm_code;
      nxt_stat = perm_stat;
    end else begin
      use_fin = 1'b1;
    end
    if (use_fin) begin
      nxt_code = fin_code;
    end
  end

  assign nxt_pa  = (use_fin && fin_code == FLT_NONE) ? fin_pa : '0;
  assign nxt_unc = use_fin && fin_unc;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      code_q  <= FLT_NONE;
      stat_q  <= '0;
      pa_q    <= '0;
      unc_q   <= 1'b0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        code_q <= nxt_code;
        stat_q <= nxt_stat;
        pa_q   <= nxt_pa;
        unc_q  <= nxt_unc;
      end else begin
        code_q <= FLT_NONE;
        stat_q <= '0;
        pa_q   <= '0;
        unc_q  <= 1'b0;
      end
    end
  end

  assign rsp_valid    = valid_q;
  assign rsp_fault    = code_q;
  assign rsp_stat     = stat_q;
  assign rsp_pa       = pa_q;
  assign rsp_uncached = unc_q;

  // ---------------- assertions ----------------
  p_resp_follows_req_r13: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && rsp_fault == 3'd0 && rsp_pa == '0));

  p_fault_blank_pa_r13: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault != 3'd0) |-> (rsp_pa == '0 && !rsp_uncached));

  p_align_first_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && |(req_va[SZ_W-1:0] & (req_size - 1'b1)))
    |=> (rsp_fault == 3'd1 && rsp_stat == ST_W'($past(req_write))));

  p_phys_identity_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_phys && !(|(req_va[SZ_W-1:0] & (req_size - 1'b1)))
     && req_va[VA_W-1:PA_W-1] == '0)
    |=> (rsp_fault == 3'd0 && rsp_pa == $past(req_va[PA_W-1:0])));

  p_window_kernel_only_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_phys && !(|(req_va[SZ_W-1:0] & (req_size - 1'b1)))
     && (&req_va[VA_W-1:SP_HI+1]) && req_va[SP_HI:SP_LO] == SP_TAG[SP_HI-SP_LO:0]
     && req_cur_mode != 2'd0)
    |=> (rsp_fault == 3'd3 && rsp_stat[ST_ACV]));

  p_miss_status_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_phys && !tlb_hit && !(|(req_va[SZ_W-1:0] & (req_size - 1'b1)))
     && req_va[VA_W-1:VA_IMPL-1] == '0)
    |=> ((rsp_fault == 3'd4 || rsp_fault == 3'd5) && rsp_stat[ST_MISS]));

  p_uncached_shape_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_uncached |-> (rsp_pa[PA_W-1] && rsp_pa[CLR_HI:CLR_LO] == '0));

endmodule

// File: tb/dtx_translate_tb.sv
module dtx_translate_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_va = '0;
  logic [3:0]  req_size = 4'd1;
  logic        req_write = 1'b0, req_phys = 1'b0, req_alt = 1'b0, req_vpte = 1'b0;
  logic [1:0]  req_cur_mode = '0, req_alt_mode = '0;
  logic        req_pal = 1'b0, tlb_hit = 1'b0;
  logic [31:0] tlb_ppn = '0;
  logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
  logic        tlb_fault_rd = 1'b0, tlb_fault_wr = 1'b0;
  logic        rsp_valid;
  logic [43:0] rsp_pa;
  logic [2:0]  rsp_fault;
  logic [5:0]  rsp_stat;
  logic        rsp_uncached;

  always #10 clk = ~clk;

  dtx_translate dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va), .req_size(req_size),
    .req_write(req_write), .req_phys(req_phys), .req_alt(req_alt), .req_vpte(req_vpte),
    .req_cur_mode(req_cur_mode), .req_alt_mode(req_alt_mode), .req_pal(req_pal),
    .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en),
    .tlb_fault_rd(tlb_fault_rd), .tlb_fault_wr(tlb_fault_wr),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_stat(rsp_stat),
    .rsp_uncached(rsp_uncached)
  );

  typedef struct {
    logic [63:0] va;
    int          size;
    bit          wr, phys, alt, vpte, pal;
    int          cm, am;
    bit          hit;
    logic [31:0] ppn;
    logic [3:0]  re, we;
    bit          fr, fw;
  } stim_t;

  int checks = 0;
  int errors = 0;
  bit exp_valid = 0;
  int exp_f = 0, exp_st = 0;
  logic [43:0] exp_pa = '0;
  bit exp_unc = 0;
  string exp_tag = "R13";
  bit finished = 0;

  // behavioural reference, written from the requirements
  function automatic void refm(input stim_t s, output int f, output int st,
                               output logic [43:0] pa, output bit unc, output string tag);
    int em;
    logic [63:0] p;
    f = 0; st = 0; pa = '0; unc = 0; p = '0;
    if ((s.va & 64'(s.size - 1)) != 0) begin
      f = 1; st = s.wr ? 1 : 0; tag = "R1"; return;
    end
    em = s.pal ? (s.alt ? s.am : 0) : s.cm;
    if (s.phys) begin
      p = s.va; tag = "R3";
    end else if (s.va[63:42] != '0 && s.va[63:42] != '1) begin
      f = 2; st = (s.wr ? 1 : 0) + 2 + 32; tag = "R4"; return;
    end else if (s.va[47:41] == 7'h7e) begin
      if (s.cm != 0) begin
        f = 3; st = (s.wr ? 1 : 0) + 2; tag = "R5"; return;
      end
      p = s.va & 64'hFFF_FFFF_FFFF;
      if (p[40]) p = p | 64'hF00_0000_0000;
      else       p = p & 64'h0FF_FFFF_FFFF;
      tag = "R6";
    end else if (!s.hit) begin
      f = s.vpte ? 4 : 5; st = 16 + (s.wr ? 1 : 0); tag = "R7"; return;
    end else begin
      p = ({32'd0, s.ppn} << 13) + {51'd0, s.va[12:0]};
      tag = "R8";
      if (s.wr) begin
        if (!s.we[em]) begin f = 2; st = 1 + 2 + (s.fw ? 8 : 0); tag = "R9 R2"; return; end
        if (s.fw) begin f = 2; st = 1 + 8; tag = "R9"; return; end
      end else begin
        if (!s.re[em]) begin f = 3; st = 2 + (s.fr ? 4 : 0); tag = "R10 R2"; return; end
        if (s.fr) begin f = 2; st = 4; tag = "R10"; return; end
      end
    end
    if ((p >> 44) != 0) begin f = 6; tag = "R11"; return; end
    if (p[43]) begin
      if (p[43:20] == '1) begin f = 7; tag = "R12"; return; end
      unc = 1; p[42:35] = '0; tag = "R12";
    end
    pa = p[43:0];
  endfunction

  task automatic compare();
    checks++;
    if (rsp_valid !== exp_valid || rsp_fault !== 3'(exp_f) || rsp_stat !== 6'(exp_st) ||
        rsp_pa !== exp_pa || rsp_uncached !== exp_unc) begin
      errors++;
      $display("FAIL %s: got v=%0b f=%0d st=%02h pa=%h u=%0b exp v=%0b f=%0d st=%02h pa=%h u=%0b",
               exp_tag, rsp_valid, rsp_fault, rsp_stat, rsp_pa, rsp_uncached,
               exp_valid, exp_f, exp_st, exp_pa, exp_unc);
    end
  endtask

  task automatic send(input stim_t s);
    int f, st;
    logic [43:0] pa;
    bit unc;
    string tag;
    @(negedge clk);
    compare();
    req_valid = 1'b1; req_va = s.va; req_size = 4'(s.size); req_write = s.wr;
    req_phys = s.phys; req_alt = s.alt; req_vpte = s.vpte; req_pal = s.pal;
    req_cur_mode = 2'(s.cm); req_alt_mode = 2'(s.am); tlb_hit = s.hit; tlb_ppn = s.ppn;
    tlb_rd_en = s.re; tlb_wr_en = s.we; tlb_fault_rd = s.fr; tlb_fault_wr = s.fw;
    refm(s, f, st, pa, unc, tag);
    exp_valid = 1; exp_f = f; exp_st = st; exp_pa = pa; exp_unc = unc; exp_tag = tag;
  endtask

  task automatic idle();
    @(negedge clk);
    compare();
    req_valid = 1'b0;
    req_va = 64'hFFFF_0000_0000_0003;
    exp_valid = 0; exp_f = 0; exp_st = 0; exp_pa = '0; exp_unc = 0; exp_tag = "R13 idle";
  endtask

  function automatic stim_t base();
    stim_t s;
    s.va = 64'h0000_0000_0012_3458; s.size = 8; s.wr = 0; s.phys = 0; s.alt = 0;
    s.vpte = 0; s.pal = 0; s.cm = 0; s.am = 0; s.hit = 1; s.ppn = 32'h0000_0ABC;
    s.re = 4'hF; s.we = 4'hF; s.fr = 0; s.fw = 0;
    return s;
  endfunction

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    stim_t s;
    repeat (3) @(negedge clk);
    // R13 reset state
    exp_tag = "R13 reset";
    compare();
    rst = 1'b0;

    // R1 misaligned store, even with physical flag set
    s = base(); s.va = 64'h1002; s.size = 4; s.wr = 1; s.phys = 1; send(s);
    s = base(); s.va = 64'h8000_0000_0000_0004; s.size = 8; send(s);
    s = base(); s.va = 64'h1001; s.size = 1; send(s);
    // R3 physical bypass
    s = base(); s.phys = 1; s.va = 64'h0000_0001_2345_6780; s.hit = 0; send(s);
    // R11 physical beyond implemented range
    s = base(); s.phys = 1; s.va = 64'h0004_0000_0000_0000; send(s);
    // R12 I/O space: register window and plain uncacheable
    s = base(); s.phys = 1; s.va = 64'h0000_0FFF_FFF0_0010; send(s);
    s = base(); s.phys = 1; s.va = 64'h0000_0FF1_2345_6780; send(s);
    // R4 invalid address
    s = base(); s.va = 64'h0000_8000_0000_0000; s.wr = 1; send(s);
    s = base(); s.va = 64'hFF00_0000_0000_0000; send(s);
    // R5 window outside kernel; firmware mode does not help
    s = base(); s.va = 64'hFFFF_FC00_0000_1000; s.cm = 3; s.pal = 1; send(s);
    s = base(); s.va = 64'hFFFF_FC00_0000_1000; s.cm = 2; s.wr = 1; send(s);
    // R6 window in kernel, bit 40 clear and set, and register window
    s = base(); s.va = 64'hFFFF_FC00_0000_1000; s.hit = 0; send(s);
    s = base(); s.va = 64'hFFFF_FD00_1234_5678; send(s);
    s = base(); s.va = 64'hFFFF_FDFF_FFF0_0000; send(s);
    // R7 misses
    s = base(); s.hit = 0; s.vpte = 1; send(s);
    s = base(); s.hit = 0; s.wr = 1; send(s);
    s = base(); s.hit = 0; s.va = 64'hFFFF_F000_0000_2000; send(s);
    // R8 hits
    s = base(); send(s);
    s = base(); s.ppn = 32'h00FF_FFFF; s.va = 64'h1FF8; s.wr = 1; send(s);
    // R9 store permissions
    s = base(); s.wr = 1; s.we = 4'hE; s.fw = 1; send(s);
    s = base(); s.wr = 1; s.we = 4'hE; send(s);
    s = base(); s.wr = 1; s.fw = 1; send(s);
    // R10 load permissions
    s = base(); s.re = 4'h0; s.fr = 1; send(s);
    s = base(); s.re = 4'hE; send(s);
    s = base(); s.fr = 1; send(s);
    // R2 effective mode selection
    s = base(); s.pal = 1; s.alt = 1; s.am = 3; s.cm = 0; s.re = 4'h8; send(s);
    s = base(); s.pal = 1; s.alt = 0; s.am = 3; s.cm = 3; s.re = 4'h1; send(s);
    s = base(); s.pal = 0; s.alt = 1; s.am = 0; s.cm = 3; s.re = 4'h1; send(s);
    s = base(); s.pal = 1; s.alt = 1; s.am = 1; s.wr = 1; s.we = 4'h1; send(s);
    // R11 through a hit; R12 through a hit
    s = base(); s.ppn = 32'h8000_0000; send(s);
    s = base(); s.ppn = 32'h4000_1234; send(s);
    // R13 idle gap between requests
    idle(); idle();
    s = base(); send(s);
    idle();

    for (int i = 0; i < 3000; i++) begin
      int cls;
      s = base();
      cls = int'($urandom_range(0, 4));
      s.va = {$urandom, $urandom};
      case (cls)
        0: s.va[63:40] = '0;
        1: s.va[63:41] = {16'hFFFF, 7'h7e};
        2: ;
        3: begin s.va[63:42] = '1; if (s.va[47:41] == 7'h7e) s.va[41] = 1'b1; end
        default: begin
          s.va[63:44] = '0; s.va[43] = 1'b1;
          if ($urandom_range(0, 1) == 0) s.va[42:20] = '1;
        end
      endcase
      s.size = 1 << $urandom_range(0, 3);
      if ($urandom_range(0, 3) != 0) s.va = s.va & ~64'(s.size - 1);
      s.phys = (cls == 4) || ($urandom_range(0, 9) == 0);
      s.wr = 1'($urandom); s.alt = 1'($urandom); s.vpte = 1'($urandom);
      s.pal = 1'($urandom); s.cm = int'($urandom_range(0, 3));
      s.am = int'($urandom_range(0, 3)); s.hit = ($urandom_range(0, 3) != 0);
      s.ppn = $urandom; if ($urandom_range(0, 1) == 0) s.ppn[31:30] = 2'b00;
      s.re = 4'($urandom); s.we = 4'($urandom);
      s.fr = ($urandom_range(0, 3) == 0); s.fw = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 15) == 0) idle();
      else send(s);
    end
    idle();
    @(negedge clk);
    compare();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule